// File: doc/BRIEF.md
# Random Number Peripheral Register Front-End

This block is the register-mapped control face of a random number source. A host writes a command word to launch either a generate pass or a reseed pass. Each pass runs for a fixed number of cycles. While it runs, a status register shows which kind of pass is busy. When a pass finishes, a sticky interrupt flag sets and stays set until the host clears it by writing a one to it. The results appear as a bank of 32-bit words. A mode bit picks a 128-bit bank of four words or a 256-bit bank of eight words.

A 32-bit Galois LFSR stands in for the generator core. It advances only while a generate pass runs. A reseed pass loads it from a seed register. If the state ever becomes all zeros, the block flags a lockup and refills the state. The host port has a write strobe with its own address and a separate combinational read address. Read data is a pure function of the read address and the current register contents.

Top module: `rngfe_top`

## Requirements
- R1: After synchronous reset, every readable register reads zero, the interrupt output is low, and the LFSR state is 32'hACE1_2468.
- R2: A command write of value 1 to offset 0x00 while idle sets status bit 30 for exactly GEN_LAT cycles, starting in the cycle after the write edge. A write of value 2 sets status bit 31 for exactly SEED_LAT cycles in the same way.
- R3: The LFSR step is next = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 0), and the LFSR advances once per cycle only while a generate runs. When a generate started from state S0 completes, result word k (offset 0x20 + 4k) reads step^(GEN_LAT+k)(S0). Until then the bank holds its previous contents.
- R4: When a reseed completes, the LFSR state equals the word held at offset 0x0C, and status bit 9 (seeded) is set and stays set.
- R5: A command write with any value other than 1 or 2 starts nothing and changes no register.
- R6: A command written while a pass is running is dropped. It neither restarts nor queues a pass.
- R7: Interrupt status offset 0x14 has bit 0 (generate done), bit 1 (reseed done) and bit 4 (lockup). Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: irq is high exactly when enable bit 31 at 0x10 is set and some status bit in {0,1,4} is set together with its enable bit.
- R9: Bit 3 of offset 0x08 selects the 256-bit bank, and status bit 3 mirrors it. When bit 3 is clear, result words 4 to 7 read zero and words 0 to 3 read the bank.
- R10: When the LFSR state is all zeros on a clock edge, the state becomes 32'hACE1_2468 and status bit 4 sets at that edge.
- R11: The enable register keeps bits 0, 1, 4 and 31. Offsets 0x0C, 0x60 and 0x64 are plain 32-bit storage that reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Byte address of the combinational read |
| rd_data | output | 32 | Read data for rd_addr |
| irq | output | 1 | Gated interrupt request |

## Verification
Let N be the first cycle after the edge that captures a command write. The busy bit is high from cycle N, and the completion effects are visible in cycle N+GEN_LAT or N+SEED_LAT. A lockup after a zero seed shows one cycle after the reseed completes. Writes to the enable or flag registers affect irq in the very next cycle. The scoreboard tags every expected read with the exact cycle it is due. The monitor compares each one in that cycle, and an item not seen in its cycle counts as a failure.

// File: rtl/rngfe_pkg.sv
package rngfe_pkg;

    localparam logic [31:0] LFSR_POLY = 32'h8020_0003;
    localparam logic [31:0] LFSR_FILL = 32'hACE1_2468;

    localparam logic [7:0] OFF_CMD    = 8'h00;
    localparam logic [7:0] OFF_STATUS = 8'h04;
    localparam logic [7:0] OFF_MODE   = 8'h08;
    localparam logic [7:0] OFF_SEED   = 8'h0C;
    localparam logic [7:0] OFF_IRQEN  = 8'h10;
    localparam logic [7:0] OFF_IRQST  = 8'h14;
    localparam logic [7:0] OFF_RES    = 8'h20;
    localparam logic [7:0] OFF_AREQ   = 8'h60;
    localparam logic [7:0] OFF_AAGE   = 8'h64;

    localparam logic [31:0] CMD_GEN  = 32'd1;
    localparam logic [31:0] CMD_SEED = 32'd2;

    localparam logic [31:0] IRQEN_KEEP = 32'h8000_0013;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GEN  = 2'd1,
        PH_SEED = 2'd2
    } phase_e;

    typedef struct packed {
        logic gen_busy;
        logic seed_busy;
        logic gen_done;
        logic seed_done;
    } seq_t;

    typedef struct packed {
        logic lock;
        logic seed;
        logic gen;
    } flags_t;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_POLY : 32'h0);
    endfunction

endpackage

// File: rtl/rngfe_seq.sv
module rngfe_seq
    import rngfe_pkg::*;
#(
    parameter int GEN_LAT  = 16,
    parameter int SEED_LAT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req_gen,
    input  logic req_seed,
    output seq_t st
);
    localparam int MAX_LAT = (GEN_LAT > SEED_LAT) ? GEN_LAT : SEED_LAT;
    localparam int CW      = $clog2(MAX_LAT + 1);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (req_gen) begin
                        ph_q  <= PH_GEN;
                        cnt_q <= CW'(GEN_LAT - 1);
                    end else if (req_seed) begin
                        ph_q  <= PH_SEED;
                        cnt_q <= CW'(SEED_LAT - 1);
                    end
                end
                default: begin
                    if (cnt_q == '0) ph_q <= PH_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        st.gen_busy  = (ph_q == PH_GEN);
        st.seed_busy = (ph_q == PH_SEED);
        st.gen_done  = st.gen_busy  && (cnt_q == '0);
        st.seed_done = st.seed_busy && (cnt_q == '0);
    end

    // R6: a command during a running pass does not reload the counter
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        ((ph_q != PH_IDLE) && (req_gen || req_seed) && (cnt_q != '0))
        |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rngfe_lfsr.sv
module rngfe_lfsr
    import rngfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step_en,
    input  logic        load_en,
    input  logic [31:0] load_val,
    output logic [31:0] state,
    output logic        zero_hit
);
    logic [31:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)                 state_q <= LFSR_FILL;
        else if (state_q == '0)  state_q <= LFSR_FILL;
        else if (load_en)        state_q <= load_val;
        else if (step_en)        state_q <= lfsr_next(state_q);
    end

    assign state    = state_q;
    assign zero_hit = (state_q == '0);

    // R10: an all-zero state never survives a clock edge
    a_r10_refill: assert property (@(posedge clk) disable iff (rst)
        (state_q == '0) |=> (state_q == LFSR_FILL));

endmodule

// File: rtl/rngfe_top.sv
module rngfe_top
    import rngfe_pkg::*;
#(
    parameter int GEN_LAT   = 16,
    parameter int SEED_LAT  = 8,
    parameter int AW        = 8,
    parameter int MAX_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          irq
);
    localparam int            HALF_WORDS = MAX_WORDS / 2;
    localparam int            IW         = $clog2(MAX_WORDS);
    localparam logic [AW-1:0] RES_BASE   = AW'(OFF_RES);
    localparam logic [AW-1:0] RES_END    = AW'(OFF_RES) + AW'(4 * MAX_WORDS);

    seq_t                         seq;
    logic [31:0]                  lf_state;
    logic                         lock_hit;
    logic                         r256_q, seeded_q;
    logic [31:0]                  seed_q, ie_q, areq_q, aage_q;
    flags_t                       flags_q, flags_set, flags_clr;
    logic [MAX_WORDS-1:0][31:0]   bank_q, chain;
    logic                         wr_cmd, req_gen, req_seed;
    logic [IW-1:0]                rd_idx;

    assign wr_cmd   = wr_en && (wr_addr == AW'(OFF_CMD));
    assign req_gen  = wr_cmd && (wr_data == CMD_GEN);
    assign req_seed = wr_cmd && (wr_data == CMD_SEED);

    rngfe_seq #(.GEN_LAT(GEN_LAT), .SEED_LAT(SEED_LAT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_gen  (req_gen),
        .req_seed (req_seed),
        .st       (seq)
    );

    rngfe_lfsr u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .step_en  (seq.gen_busy),
        .load_en  (seq.seed_done),
        .load_val (seed_q),
        .state    (lf_state),
        .zero_hit (lock_hit)
    );

    always_comb begin
        chain[0] = lfsr_next(lf_state);
        for (int k = 1; k < MAX_WORDS; k++) chain[k] = lfsr_next(chain[k-1]);
    end

    always_comb begin
        flags_set = '{lock: lock_hit, seed: seq.seed_done, gen: seq.gen_done};
        flags_clr = '0;
        if (wr_en && (wr_addr == AW'(OFF_IRQST)))
            flags_clr = '{lock: wr_data[4], seed: wr_data[1], gen: wr_data[0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r256_q   <= 1'b0;
            seeded_q <= 1'b0;
            seed_q   <= '0;
            ie_q     <= '0;
            areq_q   <= '0;
            aage_q   <= '0;
            flags_q  <= '0;
            bank_q   <= '0;
        end else begin
            flags_q <= (flags_q & ~flags_clr) | flags_set;
            if (seq.seed_done) seeded_q <= 1'b1;
            if (seq.gen_done)  bank_q   <= chain;
            if (wr_en) begin
                if (wr_addr == AW'(OFF_MODE))  r256_q <= wr_data[3];
                if (wr_addr == AW'(OFF_SEED))  seed_q <= wr_data;
                if (wr_addr == AW'(OFF_IRQEN)) ie_q   <= wr_data & IRQEN_KEEP;
                if (wr_addr == AW'(OFF_AREQ))  areq_q <= wr_data;
                if (wr_addr == AW'(OFF_AAGE))  aage_q <= wr_data;
            end
        end
    end

    assign irq = ie_q[31] && |({ie_q[4], ie_q[1], ie_q[0]} & flags_q);

    assign rd_idx = rd_addr[IW+1:2];

    always_comb begin
        rd_data = '0;
        if ((rd_addr >= RES_BASE) && (rd_addr < RES_END)) begin
            if (r256_q || (int'(rd_idx) < HALF_WORDS)) rd_data = bank_q[rd_idx];
        end else begin
            unique case (rd_addr)
                AW'(OFF_STATUS): begin
                    rd_data[31] = seq.seed_busy;
                    rd_data[30] = seq.gen_busy;
                    rd_data[9]  = seeded_q;
                    rd_data[3]  = r256_q;
                end
                AW'(OFF_MODE):  rd_data[3] = r256_q;
                AW'(OFF_SEED):  rd_data = seed_q;
                AW'(OFF_IRQEN): rd_data = ie_q;
                AW'(OFF_IRQST): begin
                    rd_data[4] = flags_q.lock;
                    rd_data[1] = flags_q.seed;
                    rd_data[0] = flags_q.gen;
                end
                AW'(OFF_AREQ):  rd_data = areq_q;
                AW'(OFF_AAGE):  rd_data = aage_q;
                default:        rd_data = '0;
            endcase
        end
    end

    // R3: the bank changes only on a generate completion
    a_r3_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !seq.gen_done |=> $stable(bank_q));

    // R7: a finished generate leaves its flag set
    a_r7_gen_flag: assert property (@(posedge clk) disable iff (rst)
        seq.gen_done |=> flags_q.gen);

    // R4: a finished reseed marks the generator seeded
    a_r4_seeded: assert property (@(posedge clk) disable iff (rst)
        seq.seed_done |=> seeded_q);

    // R10: a zero state raises the lockup flag
    a_r10_lock_flag: assert property (@(posedge clk) disable iff (rst)
        lock_hit |=> flags_q.lock);

endmodule

// File: tb/rngfe_top_tb_top.sv
`timescale 1ns/100ps
module rngfe_top_tb_top;
    localparam int GEN_LAT  = 16;
    localparam int SEED_LAT = 8;
    localparam logic [31:0] POLY = 32'h8020_0003;
    localparam logic [31:0] FILL = 32'hACE1_2468;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        int          due;
        string       tag;
    } item_t;
    item_t sb_q[$];

    logic [31:0] ms;
    logic [31:0] bank_exp [8];
    int n;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rngfe_top #(.GEN_LAT(GEN_LAT), .SEED_LAT(SEED_LAT), .AW(8), .MAX_WORDS(8)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] stepn(input logic [31:0] s, input int cnt);
        logic [31:0] v = s;
        for (int i = 0; i < cnt; i++) v = (v >> 1) ^ (v[0] ? POLY : 32'h0);
        return v;
    endfunction

    task automatic sched(input bit k, input logic [7:0] a, input logic [31:0] e,
                         input int d, input string t);
        item_t it;
        it.is_irq = k; it.addr = a; it.exp = e; it.due = d; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // generate from model state: fill bank_exp, advance model
    task automatic model_gen();
        for (int k = 0; k < 8; k++) bank_exp[k] = stepn(ms, GEN_LAT + k);
        ms = stepn(ms, GEN_LAT);
    endtask

    // monitor: pops scoreboard items in their due cycle
    initial begin
        logic [31:0] act;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                if (sb_q[0].due < cyc) begin
                    tests++; fails++;
                    $display("FAIL %s missed due cycle %0d act=none exp=%h",
                             sb_q[0].tag, sb_q[0].due, sb_q[0].exp);
                    sb_q.delete(0);
                end else if (sb_q[0].due == cyc) begin
                    if (sb_q[0].is_irq) act = {31'b0, irq};
                    else begin
                        rd_addr = sb_q[0].addr;
                        #0.5;
                        act = rd_data;
                    end
                    tests++;
                    if (act !== sb_q[0].exp) begin
                        fails++;
                        $display("FAIL %s addr=%h cyc=%0d act=%h exp=%h",
                                 sb_q[0].tag, sb_q[0].addr, cyc, act, sb_q[0].exp);
                    end
                    sb_q.delete(0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // driver
    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        ms = FILL;
        for (int k = 0; k < 8; k++) bank_exp[k] = '0;

        // R1 reset state
        n = cyc;
        sched(0, 8'h04, 32'h0, n + 1, "R1 status");
        sched(0, 8'h14, 32'h0, n + 2, "R1 irq status");
        sched(0, 8'h08, 32'h0, n + 3, "R1 mode");
        sched(0, 8'h20, 32'h0, n + 4, "R1 word0");
        sched(1, 8'h00, 32'h0, n + 5, "R1 irq");
        drain();

        // R11 storage registers
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h60, 32'h1234_5678);
        wr(8'h64, 32'h0000_00A5);
        n = cyc;
        sched(0, 8'h10, 32'h8000_0013, n + 1, "R11 enable bits");
        sched(0, 8'h60, 32'h1234_5678, n + 2, "R11 areq");
        sched(0, 8'h64, 32'h0000_00A5, n + 3, "R11 aage");
        drain();

        // R2 R4 reseed
        wr(8'h0C, 32'h0BAD_F00D);
        wr(8'h00, 32'd2);
        n = cyc;
        sched(0, 8'h04, 32'h8000_0000, n, "R2 seed busy first");
        sched(0, 8'h04, 32'h8000_0000, n + SEED_LAT - 1, "R2 seed busy last");
        sched(0, 8'h04, 32'h0000_0200, n + SEED_LAT, "R4 seeded idle");
        sched(0, 8'h14, 32'h0000_0002, n + SEED_LAT + 1, "R7 seed flag");
        sched(1, 8'h00, 32'h1, n + SEED_LAT + 2, "R8 irq seed");
        sched(0, 8'h0C, 32'h0BAD_F00D, n + SEED_LAT + 3, "R11 seed reg");
        drain();
        ms = 32'h0BAD_F00D;

        // R9 256-bit mode, R3 generate, R6 dropped commands
        wr(8'h08, 32'h0000_0008);
        n = cyc;
        sched(0, 8'h08, 32'h0000_0008, n, "R9 mode readback");
        sched(0, 8'h04, 32'h0000_0208, n + 1, "R9 status mirror");
        drain();
        wr(8'h00, 32'd1);
        n = cyc;
        model_gen();
        sched(0, 8'h04, 32'h4000_0208, n, "R2 gen busy first");
        sched(0, 8'h20, 32'h0, n + 1, "R3 bank held while busy");
        sched(0, 8'h04, 32'h4000_0208, n + GEN_LAT - 1, "R2 gen busy last");
        sched(0, 8'h04, 32'h0000_0208, n + GEN_LAT, "R6 no restart");
        for (int k = 0; k < 8; k++)
            sched(0, 8'(8'h20 + 4 * k), bank_exp[k], n + GEN_LAT + 1 + k, "R3 word");
        sched(0, 8'h14, 32'h0000_0003, n + GEN_LAT + 9, "R7 both flags");
        wr(8'h00, 32'd2);
        wr(8'h00, 32'd1);
        drain();

        // R7 write-one-to-clear
        wr(8'h14, 32'h1);
        n = cyc;
        sched(0, 8'h14, 32'h2, n, "R7 clear bit0");
        wr(8'h14, 32'h0);
        n = cyc;
        sched(0, 8'h14, 32'h2, n, "R7 zero no effect");
        sched(1, 8'h00, 32'h1, n + 1, "R8 irq held");
        wr(8'h14, 32'h2);
        n = cyc;
        sched(0, 8'h14, 32'h0, n, "R7 clear bit1");
        sched(1, 8'h00, 32'h0, n + 1, "R8 irq low");
        drain();

        // R8 gating
        wr(8'h10, 32'h0000_0013);
        wr(8'h00, 32'd1);
        n = cyc;
        model_gen();
        sched(0, 8'h14, 32'h1, n + GEN_LAT, "R8 flag set");
        sched(1, 8'h00, 32'h0, n + GEN_LAT + 1, "R8 no global enable");
        drain();
        wr(8'h10, 32'h8000_0001);
        n = cyc;
        sched(1, 8'h00, 32'h1, n, "R8 enabled");
        drain();
        wr(8'h10, 32'h8000_0002);
        n = cyc;
        sched(1, 8'h00, 32'h0, n, "R8 other enable");
        drain();
        wr(8'h14, 32'h1);
        wr(8'h10, 32'h8000_0013);

        // R9 128-bit mode
        wr(8'h08, 32'h0);
        n = cyc;
        sched(0, 8'h04, 32'h0000_0200, n, "R9 status mirror clear");
        sched(0, 8'h20, bank_exp[0], n + 1, "R9 word0");
        sched(0, 8'h2C, bank_exp[3], n + 2, "R9 word3");
        sched(0, 8'h30, 32'h0, n + 3, "R9 word4 zero");
        sched(0, 8'h3C, 32'h0, n + 4, "R9 word7 zero");
        drain();
        wr(8'h00, 32'd1);
        n = cyc;
        model_gen();
        for (int k = 0; k < 4; k++)
            sched(0, 8'(8'h20 + 4 * k), bank_exp[k], n + GEN_LAT + k, "R9 short word");
        sched(0, 8'h34, 32'h0, n + GEN_LAT + 4, "R9 word5 zero");
        sched(0, 8'h14, 32'h1, n + GEN_LAT + 5, "R7 gen flag");
        drain();
        wr(8'h14, 32'h1);

        // R5 invalid commands
        wr(8'h00, 32'd3);
        n = cyc;
        sched(0, 8'h04, 32'h0000_0200, n, "R5 cmd3 ignored");
        wr(8'h00, 32'd0);
        n = cyc;
        sched(0, 8'h04, 32'h0000_0200, n, "R5 nop ignored");
        wr(8'h00, 32'h101);
        n = cyc;
        sched(0, 8'h04, 32'h0000_0200, n, "R5 wide value ignored");
        sched(0, 8'h14, 32'h0, n + 1, "R5 no flags");
        sched(0, 8'h20, bank_exp[0], n + 2, "R5 bank kept");
        drain();

        // R10 lockup via zero seed
        wr(8'h0C, 32'h0);
        wr(8'h00, 32'd2);
        n = cyc;
        sched(0, 8'h14, 32'h02, n + SEED_LAT, "R10 seed done only");
        sched(0, 8'h14, 32'h12, n + SEED_LAT + 1, "R10 lockup flag");
        sched(1, 8'h00, 32'h1, n + SEED_LAT + 2, "R10 irq");
        drain();
        ms = FILL;
        wr(8'h14, 32'h12);
        n = cyc;
        sched(0, 8'h14, 32'h0, n, "R7 clear lockup");
        drain();
        wr(8'h00, 32'd1);
        n = cyc;
        model_gen();
        sched(0, 8'h20, bank_exp[0], n + GEN_LAT, "R10 refill word0");
        sched(0, 8'h24, bank_exp[1], n + GEN_LAT + 1, "R10 refill word1");
        drain();

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule